// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Error Flags

This block receives asynchronous serial characters on a single input line. A programmable divider produces an oversampling tick, either 16 or 8 ticks per bit period. Every bit is decided by a three-sample majority vote taken at its centre. Each character has a start bit, eight data bits sent least significant bit first, an optional ninth bit, an optional parity bit and a stop bit. Finished characters go into a two-entry buffer. Each entry keeps its own frame error and parity error flags next to its data and ninth bit.

The host side is a small register-style interface. The head character and its ninth bit are always visible. A one-cycle read strobe pops the head entry. A status byte reports the ready flag, the head entry's error flags, the overrun flag and the two mode bits. One write port has a select bit that chooses either the control byte or the status byte. When the buffer is full, a completed character waits in a holding stage. If a new start bit is then detected, that held character is dropped and overrun is flagged. In multi-processor mode, only frames whose ninth bit is one are kept. A registered interrupt request is raised when a character is waiting, as long as both enables allow it.

Top module: `serial_rx_core`

## Requirements
- R1: After reset the status byte reads 0x00 and irq_o is 0.
- R2: With status bit 4 clear, a bit period is 16·(div_i+1) clocks. Each of the 8 data bits, sent least significant bit first, is delivered on rdata_o.
- R3: With status bit 4 set, a bit period is 8·(div_i+1) clocks and data is received correctly.
- R4: Status bit 1 (frame error) is 1 for a character whose stop bit was sampled low, and 0 when the stop bit was high.
- R5: With control bit 1 set, a parity bit follows the data. Control bit 2 selects odd parity (1) or even parity (0). Status bit 2 is set only for a mismatching character.
- R6: The buffer holds two characters. Status bit 0 is 1 while at least one character is unread. A pulse on rd_i pops the head and exposes the next character's flags.
- R7: Status bit 3 (overrun) is set only when the buffer is full, a completed character is held, and a new start bit is detected. The held character is lost, and a later pop clears the flag.
- R8: With control bit 3 set, a ninth bit follows the data and appears on rbit9_o. With status bit 5 set, frames whose ninth bit is 0 are discarded.
- R9: irq_o equals, one cycle later, ready AND control bit 4 AND gie_i.
- R10: A write to the status byte changes only bits 4 and 5. The error flags are unchanged.
- R11: A low pulse that is high again at the start-bit centre sample is rejected and produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Serial line, idle high |
| div_i | input | DIV_W | Oversampling tick divider; a tick occurs every div_i+1 clocks |
| gie_i | input | 1 | Global interrupt enable |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 1 | 0 selects the control byte, 1 selects the status byte |
| wr_data_i | input | 6 | Write data. Control: 0 enable, 1 parity on, 2 odd, 3 ninth bit, 4 irq enable. Status: 4 double speed, 5 multi-processor |
| rd_i | input | 1 | Pops the head character |
| rdata_o | output | 8 | Head character data |
| rbit9_o | output | 1 | Head character ninth bit |
| stat_o | output | 8 | Status: 0 ready, 1 frame err, 2 parity err, 3 overrun, 4 double speed, 5 multi-processor |
| irq_o | output | 1 | Receive interrupt request |

## Verification
Data values are swept at both oversampling rates. The sweep covers walking-one patterns and arithmetic sequences, so bit order and both sample-centre positions are tested separately. Single faulty frames are used to show which flag each fault sets: a low stop bit, a wrong parity bit in both odd and even modes, and a glitch shorter than half a bit. Bursts of three and then four characters with no reads show that overrun depends on a new start bit and not on buffer fullness alone. Frames with the ninth bit clear and set, sent with filtering on and off, show that only non-address frames are dropped.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int OSR_SLOW = 16;
  localparam int OSR_FAST = 8;

  typedef struct packed {
    logic [7:0] data;
    logic       ninth;
    logic       ferr;
    logic       perr;
  } rx_char_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_NINE, S_PAR, S_STOP, S_HOLD
  } rx_state_t;
endpackage

// File: rtl/srx_sampler.sv
module srx_sampler
  import srx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             rxd_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             fast_i,
  input  logic             use9_i,
  input  logic             par_en_i,
  input  logic             par_odd_i,
  output logic             start_o,
  output logic             done_o,
  output rx_char_t         char_o
);
  localparam logic [4:0] LAST_S = 5'(OSR_SLOW);
  localparam logic [4:0] LAST_F = 5'(OSR_FAST);
  localparam logic [4:0] MID_S  = 5'(OSR_SLOW / 2);
  localparam logic [4:0] MID_F  = 5'(OSR_FAST / 2);

  logic [DIV_W-1:0] bcnt;
  logic             tick;
  logic [1:0]       sync_q;
  logic             rx;
  rx_state_t        st;
  logic [4:0]       phase;
  logic [2:0]       bitn;
  logic [7:0]       shreg;
  logic             ninth_q, psum, s0, s1;
  logic [4:0]       last_ph, mid_ph;
  logic             maj, decide, end_bit;

  assign tick    = (bcnt == '0);
  assign rx      = sync_q[1];
  assign last_ph = fast_i ? LAST_F : LAST_S;
  assign mid_ph  = fast_i ? MID_F : MID_S;
  assign maj     = (s0 & s1) | (s0 & rx) | (s1 & rx);
  assign decide  = (phase == mid_ph + 5'd1);
  assign end_bit = (phase == last_ph);

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt   <= '0;
      sync_q <= 2'b11;
    end else begin
      bcnt   <= tick ? div_i : bcnt - 1'b1;
      sync_q <= {sync_q[0], rxd_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      phase   <= 5'd1;
      bitn    <= '0;
      shreg   <= '0;
      ninth_q <= 1'b0;
      psum    <= 1'b0;
      s0      <= 1'b1;
      s1      <= 1'b1;
      start_o <= 1'b0;
      done_o  <= 1'b0;
      char_o  <= '0;
    end else begin
      start_o <= 1'b0;
      done_o  <= 1'b0;
      if (!en) begin
        st <= S_IDLE;
      end else if (tick) begin
        case (st)
          S_IDLE: begin
            if (!rx) begin
              st      <= S_START;
              phase   <= 5'd1;
              psum    <= 1'b0;
              ninth_q <= 1'b0;
              start_o <= 1'b1;
            end
          end
          S_HOLD: begin
            if (rx) st <= S_IDLE;
          end
          default: begin
            if (phase == mid_ph - 5'd1) s0 <= rx;
            if (phase == mid_ph) s1 <= rx;
            if (st == S_START && phase == mid_ph && rx) begin
              st <= S_IDLE;
            end else if (decide) begin
              phase <= phase + 5'd1;
              case (st)
                S_DATA: begin
                  shreg <= {maj, shreg[7:1]};
                  psum  <= psum ^ maj;
                end
                S_NINE: begin
                  ninth_q <= maj;
                  psum    <= psum ^ maj;
                end
                S_PAR: psum <= psum ^ maj;
                S_STOP: begin
                  done_o       <= 1'b1;
                  char_o.data  <= shreg;
                  char_o.ninth <= ninth_q;
                  char_o.ferr  <= ~maj;
                  char_o.perr  <= par_en_i && (psum != par_odd_i);
                  st           <= maj ? S_IDLE : S_HOLD;
                end
                default: ;
              endcase
            end else if (end_bit) begin
              phase <= 5'd1;
              case (st)
                S_START: begin
                  st   <= S_DATA;
                  bitn <= '0;
                end
                S_DATA: begin
                  if (bitn == 3'd7)
                    st <= use9_i ? S_NINE : (par_en_i ? S_PAR : S_STOP);
                  bitn <= bitn + 3'd1;
                end
                S_NINE: st <= par_en_i ? S_PAR : S_STOP;
                S_PAR:  st <= S_STOP;
                default: ;
              endcase
            end else begin
              phase <= phase + 5'd1;
            end
          end
        endcase
      end
    end
  end

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE && st != S_HOLD) |-> (phase >= 5'd1 && phase <= LAST_S));

  // R4
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && char_o.ferr) |-> (st == S_HOLD));
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     push,
  input  rx_char_t wdata,
  input  logic     pop,
  output rx_char_t rdata,
  output logic     full,
  output logic     empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  rx_char_t        mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [CW-1:0]   cnt;
  logic            pop_ok, push_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNT_MAX);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= (wp == PTR_MAX) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == PTR_MAX) ? '0 : rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full) |-> pop);
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import srx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxd_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             gie_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [5:0]       wr_data_i,
  input  logic             rd_i,
  output logic [7:0]       rdata_o,
  output logic             rbit9_o,
  output logic [7:0]       stat_o,
  output logic             irq_o
);
  logic     en_q, par_en_q, par_odd_q, use9_q, irq_en_q, fast_q, mp_q;
  logic     start_evt, done_evt, done_acc;
  rx_char_t done_chr, pend, head, push_chr;
  logic     pend_v, ovr_q, irq_q;
  logic     full, empty, ready, pop, can_push, push, ovr_hit;

  srx_sampler #(.DIV_W(DIV_W)) u_smp (
    .clk(clk), .rst(rst), .en(en_q), .rxd_i(rxd_i), .div_i(div_i),
    .fast_i(fast_q), .use9_i(use9_q), .par_en_i(par_en_q),
    .par_odd_i(par_odd_q), .start_o(start_evt), .done_o(done_evt),
    .char_o(done_chr)
  );

  srx_fifo #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst(rst), .push(push), .wdata(push_chr), .pop(pop),
    .rdata(head), .full(full), .empty(empty)
  );

  assign ready    = !empty;
  assign pop      = rd_i && ready;
  assign can_push = !full || pop;
  assign done_acc = done_evt && !(mp_q && !done_chr.ninth);
  assign ovr_hit  = start_evt && pend_v && full && !pop;

  always_comb begin
    push     = 1'b0;
    push_chr = pend;
    if (pend_v && can_push) begin
      push = 1'b1;
    end else if (done_acc && can_push) begin
      push     = 1'b1;
      push_chr = done_chr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; par_en_q <= 1'b0; par_odd_q <= 1'b0;
      use9_q <= 1'b0; irq_en_q <= 1'b0; fast_q <= 1'b0; mp_q <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_sel_i) begin
        fast_q <= wr_data_i[4];
        mp_q   <= wr_data_i[5];
      end else begin
        en_q      <= wr_data_i[0];
        par_en_q  <= wr_data_i[1];
        par_odd_q <= wr_data_i[2];
        use9_q    <= wr_data_i[3];
        irq_en_q  <= wr_data_i[4];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
      pend   <= '0;
      ovr_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= ready && irq_en_q && gie_i;
      if (ovr_hit)   ovr_q <= 1'b1;
      else if (pop)  ovr_q <= 1'b0;
      if (ovr_hit) begin
        pend_v <= 1'b0;
      end else if (pend_v && can_push) begin
        if (done_acc) pend <= done_chr;
        else          pend_v <= 1'b0;
      end else if (done_acc && !can_push) begin
        pend_v <= 1'b1;
        pend   <= done_chr;
      end
    end
  end

  assign rdata_o = head.data;
  assign rbit9_o = head.ninth;
  assign irq_o   = irq_q;
  assign stat_o  = {2'b00, mp_q, fast_q, ovr_q,
                    ready & head.perr, ready & head.ferr, ready};

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(ready && irq_en_q && gie_i));

  // R7
  ovr_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_q) |-> $past(pend_v && full && start_evt));

  // R8
  mp_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (done_evt && mp_q && !done_chr.ninth && !pend_v) |-> !push);

  // R10
  errs_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_sel_i && ready && !rd_i) |=> $stable({head.ferr, head.perr}));
endmodule

// File: tb/sim_serial_rx_core.sv
module sim_serial_rx_core;
  localparam int DIV = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic [15:0] div = 16'(DIV);
  logic       gie = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, rd = 1'b0;
  logic [5:0] wr_data = '0;
  logic [7:0] rdata, stat;
  logic       rbit9, irq;

  int total = 0, bad = 0;
  bit finished = 0;

  // bench-side mirror of configuration
  bit fast = 0, mp = 0, use9 = 0, par_en = 0, par_odd = 0;

  always #2 clk = ~clk;

  serial_rx_core u0 (
    .clk(clk), .rst(rst), .rxd_i(rxd), .div_i(div), .gie_i(gie),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_i(rd),
    .rdata_o(rdata), .rbit9_o(rbit9), .stat_o(stat), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int bit_clks();
    return (fast ? 8 : 16) * (DIV + 1);
  endfunction

  function automatic int estat(bit rdy, bit fe, bit pe, bit ov);
    return {mp, fast, ov, pe, fe, rdy};
  endfunction

  task automatic wr(input bit sel, input logic [5:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_ctrl(input bit ie);
    wr(1'b0, {1'b0, ie, use9, par_odd, par_en, 1'b1});
  endtask

  task automatic set_mode();
    wr(1'b1, {mp, fast, 4'b0000});
  endtask

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (bit_clks()) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit n9, input bit bad_stop,
                      input bit bad_par);
    logic p;
    p = (^d) ^ (use9 ? n9 : 1'b0) ^ par_odd ^ bad_par;
    @(negedge clk);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (use9) drive_bit(n9);
    if (par_en) drive_bit(p);
    drive_bit(~bad_stop);
    rxd = 1'b1;
    repeat (2 * bit_clks()) @(negedge clk);
  endtask

  task automatic pop();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 stat", stat, 0);
    chk("R1 irq", irq, 0);

    gie = 1'b1;
    set_ctrl(1'b1);

    // R2 sweep at 16x: walking ones then arithmetic patterns
    for (int i = 0; i < 14; i++) begin
      logic [7:0] d;
      d = (i < 8) ? 8'(1 << i) : 8'(i * 53 + 7);
      send(d, 1'b0, 1'b0, 1'b0);
      chk("R2 data", rdata, d);
      chk("R2 stat", stat, estat(1, 0, 0, 0));
      pop();
      chk("R6 empty after pop", stat, estat(0, 0, 0, 0));
    end

    // R9 interrupt gating
    send(8'hC3, 1'b0, 1'b0, 1'b0);
    chk("R9 irq on", irq, 1);
    gie = 1'b0; @(negedge clk);
    chk("R9 irq gie low", irq, 0);
    gie = 1'b1; set_ctrl(1'b0); @(negedge clk);
    chk("R9 irq disabled", irq, 0);
    set_ctrl(1'b1);
    pop(); @(negedge clk);
    chk("R9 irq empty", irq, 0);

    // R3 sweep at 8x
    fast = 1; set_mode();
    for (int i = 0; i < 10; i++) begin
      logic [7:0] d;
      d = 8'(i * 29 + 255 - i);
      send(d, 1'b0, 1'b0, 1'b0);
      chk("R3 data", rdata, d);
      chk("R3 stat", stat, estat(1, 0, 0, 0));
      pop();
    end
    fast = 0; set_mode();

    // R4 bad stop then good, flags travel with entries (R6)
    send(8'h96, 1'b0, 1'b1, 1'b0);
    send(8'h69, 1'b0, 1'b0, 1'b0);
    chk("R4 bad stop data", rdata, 8'h96);
    chk("R4 ferr set", stat, estat(1, 1, 0, 0));
    // R10 status write with error bits set changes only mode bits
    fast = 1;
    wr(1'b1, 6'b011111);
    chk("R10 errs kept", stat, estat(1, 1, 0, 0));
    fast = 0; set_mode();
    pop();
    chk("R6 next data", rdata, 8'h69);
    chk("R4 ferr clear", stat, estat(1, 0, 0, 0));
    pop();

    // R5 parity, even and odd
    par_en = 1;
    for (int k = 0; k < 4; k++) begin
      par_odd = k[1];
      set_ctrl(1'b1);
      send(8'h5B ^ 8'(k), 1'b0, 1'b0, k[0]);
      chk("R5 data", rdata, 8'h5B ^ 8'(k));
      chk("R5 perr", stat, estat(1, 0, k[0], 0));
      pop();
    end
    par_en = 0; par_odd = 0; set_ctrl(1'b1);

    // R8 ninth bit and address filter
    use9 = 1; set_ctrl(1'b1);
    mp = 1; set_mode();
    send(8'h11, 1'b0, 1'b0, 1'b0);
    chk("R8 data frame dropped", stat, estat(0, 0, 0, 0));
    send(8'h22, 1'b1, 1'b0, 1'b0);
    chk("R8 addr data", rdata, 8'h22);
    chk("R8 addr ninth", rbit9, 1);
    chk("R8 addr stat", stat, estat(1, 0, 0, 0));
    pop();
    mp = 0; set_mode();
    send(8'h33, 1'b0, 1'b0, 1'b0);
    chk("R8 unfiltered data", rdata, 8'h33);
    chk("R8 unfiltered ninth", rbit9, 0);
    pop();
    use9 = 0; set_ctrl(1'b1);

    // R7 overrun: three chars do not overrun, the fourth start does
    send(8'hA1, 1'b0, 1'b0, 1'b0);
    send(8'hA2, 1'b0, 1'b0, 1'b0);
    send(8'hA3, 1'b0, 1'b0, 1'b0);
    chk("R7 no overrun yet", stat, estat(1, 0, 0, 0));
    send(8'hA4, 1'b0, 1'b0, 1'b0);
    chk("R7 overrun set", stat, estat(1, 0, 0, 1));
    chk("R7 head 1", rdata, 8'hA1);
    pop();
    chk("R7 overrun cleared", stat, estat(1, 0, 0, 0));
    chk("R7 head 2", rdata, 8'hA2);
    pop();
    chk("R7 head 4", rdata, 8'hA4);
    pop();
    chk("R7 drained", stat, estat(0, 0, 0, 0));

    // R11 start glitch rejected
    @(negedge clk);
    rxd = 1'b0;
    repeat (2 * (DIV + 1)) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * bit_clks()) @(negedge clk);
    chk("R11 glitch ignored", stat, estat(0, 0, 0, 0));
    send(8'h7E, 1'b0, 1'b0, 1'b0);
    chk("R11 next frame ok", rdata, 8'h7E);
    pop();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule